// File: doc/BRIEF.md
# Triggered Exposure Sequencer

This block runs the triggered-exposure mode of a CCD timing generator. It sits beside the horizontal line counter and the vertical sync generator. It decides when the sensor is flushed, when exposure starts and when the accumulated charge is moved into the vertical register. When the mode is enabled and no trigger has been seen, every line strobe produces a discharge pulse. This keeps the photosites empty, and readout is held back.

A falling edge on the asynchronous trigger input passes through a synchroniser. It then forces a one-cycle line-reset request, so the line counter restarts at the trigger instant. It also produces one final discharge pulse, and exposure begins. Line strobes are counted from that point. After the programmed number of lines, a readout pulse and a write-enable pulse are issued together. Their timing has no relation to vertical sync. The sequencer then returns to the waiting state. While the mode is enabled, a halt signal tells the vertical sync and field logic to stop.

Top module: `trig_expo_seq`

## Requirements
- R1: While waiting for a trigger, each cycle in which `line_strobe` is high produces `discharge_pulse` from the next cycle on, lasting DIS_W cycles (2 in the tested configuration).
- R2: `readout_pulse` and `wr_en_pulse` stay low while waiting for a trigger and while the mode is disabled.
- R3: A high-to-low transition of `trig_in`, sampled by a two-flop synchroniser, raises `line_reset_req` for exactly one cycle. The pulse begins three rising clock edges after the first edge that samples the low level. A low-to-high transition has no effect.
- R4: The trigger produces one last `discharge_pulse`, starting in the same cycle as `line_reset_req`. No further discharge pulse occurs before readout.
- R5: Exposure length N is taken from `expo_lines` at the trigger, with the value 0 treated as 1. The N-th `line_strobe` after the trigger starts `readout_pulse` in the next cycle, lasting RD_W cycles (3 in the tested configuration). A strobe in the trigger cycle itself is not counted.
- R6: `wr_en_pulse` is high in exactly the same cycles as `readout_pulse`.
- R7: `vsync_halt` is high from one cycle after `mode_en` rises and low from one cycle after it falls. Disabling the mode aborts any exposure and clears pulses in progress at the next edge.
- R8: Trigger edges during exposure produce no `line_reset_req`. Changes of `expo_lines` during exposure do not move the readout.
- R9: After readout the block is waiting again: the next strobe discharges and the next trigger starts a new exposure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | Enables triggered-exposure mode |
| line_strobe | input | 1 | One-cycle pulse at each line start |
| trig_in | input | 1 | Asynchronous trigger, active on falling edge, idle high |
| expo_lines | input | CNT_W | Exposure length in lines |
| discharge_pulse | output | 1 | Sensor charge-discharge pulse |
| readout_pulse | output | 1 | Sensor-to-vertical-register transfer pulse |
| line_reset_req | output | 1 | Request to restart horizontal timing |
| wr_en_pulse | output | 1 | Frame-store write start marker |
| vsync_halt | output | 1 | Stops vertical sync and field outputs |

## Verification
The hardest situation to reach is a trigger edge that arrives while an exposure is already counting lines, combined with a change of the exposure setting in mid-flight. The bench reaches it by lowering and raising `trig_in` and rewriting `expo_lines` right after a trigger has been accepted. It then checks that no reset request appears and that readout still lands on the latched line count. A sweep over every exposure length from 0 to 7 covers the zero clamp and the readout position. A separate case switches the mode off during an exposure and during a live discharge pulse.

// File: rtl/trig_expo_pkg.sv
package trig_expo_pkg;
   typedef enum logic [1:0] {
      ST_OFF    = 2'd0,
      ST_WAIT   = 2'd1,
      ST_EXPOSE = 2'd2
   } seq_state_e;
endpackage

// File: rtl/rte_trig_sync.sv
module rte_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic fall_det
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         initial $error("rte_trig_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign fall_det = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/rte_pulse_stretch.sv
module rte_pulse_stretch #(
   parameter int WIDTH = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic clr,
   output logic pulse
);
   generate
      if (WIDTH < 1) begin : g_bad
         initial $error("rte_pulse_stretch: WIDTH must be at least 1");
      end else if (WIDTH == 1) begin : g_single
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= go & ~clr;
         end
         assign pulse = q;
      end else begin : g_count
         localparam int RW = $clog2(WIDTH + 1);
         logic [RW-1:0] rem_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr)    rem_q <= '0;
            else if (go)          rem_q <= RW'(WIDTH);
            else if (rem_q != '0) rem_q <= rem_q - 1'b1;
         end
         assign pulse = (rem_q != '0);
      end
   endgenerate
endmodule

// File: rtl/rte_line_count.sv
module rte_line_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len_in,
   input  logic             count_en,
   output logic             done
);
   logic [CNT_W-1:0] target_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   next_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         target_q <= CNT_W'(1);
         cnt_q    <= '0;
      end else if (load) begin
         target_q <= (len_in == '0) ? CNT_W'(1) : len_in;
         cnt_q    <= '0;
      end else if (count_en) begin
         cnt_q    <= next_cnt[CNT_W-1:0];
      end
   end

   assign next_cnt = {1'b0, cnt_q} + 1'b1;
   assign done     = count_en && (next_cnt >= {1'b0, target_q});
endmodule

// File: rtl/trig_expo_seq.sv
module trig_expo_seq
   import trig_expo_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int DIS_W       = 2,
   parameter int RD_W        = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_en,
   input  logic             line_strobe,
   input  logic             trig_in,
   input  logic [CNT_W-1:0] expo_lines,
   output logic             discharge_pulse,
   output logic             readout_pulse,
   output logic             line_reset_req,
   output logic             wr_en_pulse,
   output logic             vsync_halt
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         initial $error("trig_expo_seq: CNT_W must be at least 1");
      end
   endgenerate

   seq_state_e state_q, state_d;
   logic       trig_fall;
   logic       expo_done;
   logic       fire_trig, fire_dis, fire_rd;
   logic       abort;
   logic       rst_req_q;

   rte_trig_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_in(trig_in), .fall_det(trig_fall)
   );

   assign abort     = ~mode_en;
   assign fire_trig = mode_en && (state_q == ST_WAIT) && trig_fall;
   assign fire_dis  = mode_en && (state_q == ST_WAIT) && (line_strobe || trig_fall);

   rte_line_count #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .load(fire_trig), .len_in(expo_lines),
      .count_en(mode_en && (state_q == ST_EXPOSE) && line_strobe),
      .done(expo_done)
   );

   assign fire_rd = expo_done;

   always_comb begin
      state_d = state_q;
      if (!mode_en) begin
         state_d = ST_OFF;
      end else begin
         unique case (state_q)
            ST_OFF:    state_d = ST_WAIT;
            ST_WAIT:   if (trig_fall) state_d = ST_EXPOSE;
            ST_EXPOSE: if (expo_done) state_d = ST_WAIT;
            default:   state_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_OFF;
         rst_req_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         rst_req_q <= fire_trig;
      end
   end

   rte_pulse_stretch #(.WIDTH(DIS_W)) dis_i (
      .clk(clk), .rst_n(rst_n), .go(fire_dis), .clr(abort), .pulse(discharge_pulse)
   );
   rte_pulse_stretch #(.WIDTH(RD_W)) rd_i (
      .clk(clk), .rst_n(rst_n), .go(fire_rd), .clr(abort), .pulse(readout_pulse)
   );
   rte_pulse_stretch #(.WIDTH(RD_W)) wen_i (
      .clk(clk), .rst_n(rst_n), .go(fire_rd), .clr(abort), .pulse(wr_en_pulse)
   );

   assign line_reset_req = rst_req_q;
   assign vsync_halt     = (state_q != ST_OFF);
endmodule

// File: rtl/trig_expo_seq_chk.sv
module trig_expo_seq_chk
   import trig_expo_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       mode_en,
   input logic       discharge_pulse,
   input logic       readout_pulse,
   input logic       line_reset_req,
   input logic       wr_en_pulse,
   input logic       vsync_halt,
   input seq_state_e state_q
);
   p_dis_only_waiting_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(discharge_pulse) |-> $past(state_q) == ST_WAIT);

   p_rd_only_exposing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(readout_pulse) |-> $past(state_q) == ST_EXPOSE);

   p_no_rd_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OFF) |-> !readout_pulse);

   p_single_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      line_reset_req |=> !line_reset_req);

   p_last_discharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      line_reset_req |-> discharge_pulse);

   p_wen_tracks_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      readout_pulse == wr_en_pulse);

   p_halt_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_en |=> !vsync_halt);
endmodule

bind trig_expo_seq trig_expo_seq_chk chk_i (
   .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
   .discharge_pulse(discharge_pulse), .readout_pulse(readout_pulse),
   .line_reset_req(line_reset_req), .wr_en_pulse(wr_en_pulse),
   .vsync_halt(vsync_halt), .state_q(state_q)
);

// File: tb/trig_expo_seq_tb_top.sv
module trig_expo_seq_tb_top;
   localparam int CLK_P    = 10;
   localparam int CNT_W    = 4;
   localparam int DIS_W    = 2;
   localparam int RD_W     = 3;
   localparam int WDOG_CYC = 150000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             mode_en = 1'b0;
   logic             line_strobe = 1'b0;
   logic             trig_in = 1'b1;
   logic [CNT_W-1:0] expo_lines = '0;
   logic             discharge_pulse, readout_pulse, line_reset_req, wr_en_pulse, vsync_halt;

   int n_checks = 0;
   int n_fail   = 0;
   bit done_flag = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   trig_expo_seq #(.CNT_W(CNT_W), .DIS_W(DIS_W), .RD_W(RD_W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .line_strobe(line_strobe),
      .trig_in(trig_in), .expo_lines(expo_lines),
      .discharge_pulse(discharge_pulse), .readout_pulse(readout_pulse),
      .line_reset_req(line_reset_req), .wr_en_pulse(wr_en_pulse),
      .vsync_halt(vsync_halt)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   // Drive one strobe; on return the registered response is visible.
   task automatic strobe();
      line_strobe = 1'b1;
      tick();
      line_strobe = 1'b0;
   endtask

   // Falling trigger edge; on return the third edge after sampling has passed.
   task automatic trigger_fall();
      trig_in = 1'b0;
      idle(3);
   endtask

   task automatic check_readout_width(input string req);
      for (int k = 1; k < RD_W; k++) begin
         tick();
         chk(req, readout_pulse, 1'b1);
         chk("R6", wr_en_pulse, 1'b1);
      end
      tick();
      chk(req, readout_pulse, 1'b0);
      chk("R6", wr_en_pulse, 1'b0);
   endtask

   initial begin
      idle(3);
      chk("R7 reset halt", vsync_halt, 1'b0);
      chk("R2 reset readout", readout_pulse, 1'b0);
      chk("R3 reset lreq", line_reset_req, 1'b0);
      chk("R1 reset discharge", discharge_pulse, 1'b0);
      rst_n = 1'b1;
      tick();

      // R7/R2: disabled mode ignores strobes and triggers
      strobe();
      chk("R7 off discharge", discharge_pulse, 1'b0);
      trigger_fall();
      chk("R7 off trigger", line_reset_req, 1'b0);
      trig_in = 1'b1;
      idle(4);

      mode_en = 1'b1;
      tick();
      chk("R7 halt on", vsync_halt, 1'b1);
      idle(2);

      // Sweep exposure lengths, including the zero clamp
      for (int e = 0; e < 8; e++) begin
         int eff;
         eff = (e == 0) ? 1 : e;
         expo_lines = CNT_W'(e);

         // R1: idle discharge per strobe, DIS_W cycles long
         strobe();
         chk("R1 dis start", discharge_pulse, 1'b1);
         chk("R2 no rd waiting", readout_pulse, 1'b0);
         idle(DIS_W - 1);
         chk("R1 dis hold", discharge_pulse, 1'b1);
         tick();
         chk("R1 dis end", discharge_pulse, 1'b0);
         idle(2);

         // R3/R4: trigger produces line reset and last discharge
         trigger_fall();
         chk("R3 lreq", line_reset_req, 1'b1);
         chk("R4 last dis", discharge_pulse, 1'b1);
         tick();
         chk("R3 lreq single", line_reset_req, 1'b0);
         trig_in = 1'b1;
         // R8: trigger glitch and setting change during exposure
         expo_lines = CNT_W'(15);
         idle(3);
         trig_in = 1'b0;
         for (int g = 0; g < 5; g++) begin
            tick();
            chk("R8 ignored trig", line_reset_req, 1'b0);
         end
         trig_in = 1'b1;
         idle(3);

         // R5: readout after the eff-th strobe
         for (int ln = 1; ln <= eff; ln++) begin
            strobe();
            chk("R4 no dis exposing", discharge_pulse, 1'b0);
            chk("R5 rd timing", readout_pulse, (ln == eff));
            chk("R6 wen timing", wr_en_pulse, (ln == eff));
            if (ln == eff) check_readout_width("R5 rd width");
            else idle(RD_W + 1);
         end
         chk("R7 halt kept", vsync_halt, 1'b1);
         idle(2);
         // R9: back to waiting
         strobe();
         chk("R9 dis again", discharge_pulse, 1'b1);
         chk("R2 no rd after", readout_pulse, 1'b0);
         idle(DIS_W + 2);
      end

      // R5: strobe in the trigger cycle is not counted (exposure of 2)
      expo_lines = CNT_W'(2);
      trig_in = 1'b0;
      idle(2);
      strobe();
      chk("R3 lreq coinc", line_reset_req, 1'b1);
      chk("R4 dis coinc", discharge_pulse, 1'b1);
      trig_in = 1'b1;
      idle(4);
      strobe();
      chk("R5 not counted", readout_pulse, 1'b0);
      idle(3);
      strobe();
      chk("R5 second line", readout_pulse, 1'b1);
      idle(RD_W + 2);

      // R7: abort during exposure and during a discharge pulse
      expo_lines = CNT_W'(5);
      trigger_fall();
      trig_in = 1'b1;
      idle(3);
      strobe();
      mode_en = 1'b0;
      tick();
      chk("R7 halt off", vsync_halt, 1'b0);
      strobe();
      chk("R7 off no dis", discharge_pulse, 1'b0);
      mode_en = 1'b1;
      idle(2);
      strobe();
      chk("R7 re-enabled waiting", discharge_pulse, 1'b1);
      mode_en = 1'b0;
      tick();
      chk("R7 abort clears dis", discharge_pulse, 1'b0);
      idle(3);

      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < WDOG_CYC; c++) @(posedge clk);
      if (!done_flag) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule